// File: doc/BRIEF.md
# Multi-Sector Transfer Tracker

This block follows one multi-sector read or write command from issue to end. When a command is started it takes the sector count the host supplied, treats a value of zero as the largest possible transfer (256 sectors with the default 8-bit count), and then counts the per-sector completion strobes that the data path reports. While it runs it drives the busy and data-request status bits. After each sector it holds busy for a programmable settling time before it raises data-request again.

Two kinds of error can arrive. A correctable error sets a sticky "corrected" flag and the transfer goes on. A fatal error stops the command at once. The sector in flight is then not counted, the error flag is set, and the supplied cause code is latched. At the end of every command the block writes the sector count back, zero after a full transfer and the number of sectors still owed after a failure. It also emits a one-cycle completion pulse that can serve as an interrupt request.

Top module: `mst_xfer_tracker`

## Requirements
- R1: A start count of 0 means 2^CNT_W sectors (256 by default). The command completes only after that many accepted sector strobes.
- R2: After the last sector is accepted, the command ends with `sec_count` = 0 and `st_err` = 0.
- R3: A fatal error ends the command with `sec_count` equal to the low CNT_W bits of the sectors not yet accepted. When `fatal_err` and `sec_done` arrive in the same cycle, that sector is not accepted.
- R4: `corr_err` during an active command sets `st_corr`, which stays set until the next start. It neither stops nor shortens the transfer.
- R5: After a start, and after each accepted sector that is not the last, `st_bsy` is 1 for exactly SETTLE_CYC cycles. Then `st_drq` is 1 until the next sector is accepted or the command fails.
- R6: `st_bsy` and `st_drq` are never both 1, and both are 0 when no command is active.
- R7: A fatal error during an active command sets `st_err` and latches `fatal_cause` into `err_code`. A start clears `st_err`, `st_corr` and `err_code` to 0.
- R8: `done` is a single-cycle pulse, given exactly once per command, in the first cycle in which `st_bsy` and `st_drq` are both 0 again.
- R9: Several inputs are ignored. `cmd_start` during an active command has no effect. `sec_done` is ignored unless `st_drq` is 1. `fatal_err` and `corr_err` are ignored while idle.
- R10: An accepted start loads `sec_count` with `cmd_count` in the next cycle. The value holds until the command ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe for a new command |
| cmd_count | input | CNT_W | Sector count given with the start (0 = maximum) |
| sec_done | input | 1 | One sector moved by the data path |
| corr_err | input | 1 | Correctable error strobe |
| fatal_err | input | 1 | Uncorrectable error strobe |
| fatal_cause | input | CODE_W | Cause code latched with a fatal error |
| st_bsy | output | 1 | Busy status |
| st_drq | output | 1 | Data-request status |
| st_corr | output | 1 | Corrected-data status |
| st_err | output | 1 | Error status |
| err_code | output | CODE_W | Latched cause of the last failure |
| done | output | 1 | Completion pulse |
| sec_count | output | CNT_W | Sector count register value |

## Verification
On every cycle, the assertions check that busy and data-request are exclusive, and that data-request only rises out of busy. They also check that the completion pulse lasts one cycle and lands in idle, that a good completion leaves a zero count, that a start clears both flags and loads the count, and that an idle block without a start stays unchanged. Other behaviour depends on whole command histories, and only the bench scenarios reach it. These are the exact residual count after failures at several points, the priority of a fatal error over a same-cycle sector strobe, the full 256-sector run from a zero count, and the length of each settling window.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_MOVE   = 2'd2
  } phase_t;
endpackage

// File: rtl/mst_phase_ctrl.sv
module mst_phase_ctrl
  import mst_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_start,
  input  logic   sec_done,
  input  logic   fatal_err,
  input  logic   last_sector,
  output phase_t phase,
  output logic   accept,
  output logic   take,
  output logic   fin_ok,
  output logic   fin_fail,
  output logic   bsy_q,
  output logic   drq_q,
  output logic   done_q
);
  localparam int WC_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [WC_W-1:0] WC_INIT = WC_W'(SETTLE_CYC - 1);

  phase_t          nxt;
  logic [WC_W-1:0] wcnt, wcnt_nxt;

  always_comb begin
    accept   = (phase == PH_IDLE) && cmd_start;
    fin_fail = (phase != PH_IDLE) && fatal_err;
    take     = (phase == PH_MOVE) && sec_done && !fatal_err;
    fin_ok   = take && last_sector;
    nxt      = phase;
    wcnt_nxt = wcnt;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          nxt      = PH_SETTLE;
          wcnt_nxt = WC_INIT;
        end
      end
      PH_SETTLE: begin
        if (fin_fail)          nxt = PH_IDLE;
        else if (wcnt == '0)   nxt = PH_MOVE;
        else                   wcnt_nxt = wcnt - 1'b1;
      end
      PH_MOVE: begin
        if (fin_fail || fin_ok) nxt = PH_IDLE;
        else if (take) begin
          nxt      = PH_SETTLE;
          wcnt_nxt = WC_INIT;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      wcnt   <= '0;
      bsy_q  <= 1'b0;
      drq_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      phase  <= nxt;
      wcnt   <= wcnt_nxt;
      bsy_q  <= (nxt == PH_SETTLE);
      drq_q  <= (nxt == PH_MOVE);
      done_q <= fin_ok || fin_fail;
    end
  end
endmodule

// File: rtl/mst_sector_counter.sv
module mst_sector_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             fin_ok,
  input  logic             fin_fail,
  output logic             last_sector,
  output logic [CNT_W-1:0] count_q
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] REM_MAX = REM_W'(1) << CNT_W;
  localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

  logic [REM_W-1:0] remain;

  assign last_sector = (remain == REM_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      count_q <= '0;
    end else begin
      if (load) begin
        remain  <= (load_val == '0) ? REM_MAX : {1'b0, load_val};
        count_q <= load_val;
      end else if (dec) begin
        remain <= remain - REM_ONE;
      end
      if (fin_ok)        count_q <= '0;
      else if (fin_fail) count_q <= remain[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mst_status_flags.sv
module mst_status_flags #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              active,
  input  logic              corr_in,
  input  logic              fail,
  input  logic [CODE_W-1:0] cause,
  output logic              corr_q,
  output logic              err_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      corr_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (active && corr_in) corr_q <= 1'b1;
      if (fail) begin
        err_q  <= 1'b1;
        code_q <= cause;
      end
    end
  end
endmodule

// File: rtl/mst_xfer_tracker.sv
module mst_xfer_tracker
  import mst_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              sec_done,
  input  logic              corr_err,
  input  logic              fatal_err,
  input  logic [CODE_W-1:0] fatal_cause,
  output logic              st_bsy,
  output logic              st_drq,
  output logic              st_corr,
  output logic              st_err,
  output logic [CODE_W-1:0] err_code,
  output logic              done,
  output logic [CNT_W-1:0]  sec_count
);
  phase_t phase;
  logic   accept, take, fin_ok, fin_fail, last_sector;

  mst_phase_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .sec_done(sec_done),
    .fatal_err(fatal_err), .last_sector(last_sector), .phase(phase),
    .accept(accept), .take(take), .fin_ok(fin_ok), .fin_fail(fin_fail),
    .bsy_q(st_bsy), .drq_q(st_drq), .done_q(done)
  );

  mst_sector_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .load_val(cmd_count), .dec(take),
    .fin_ok(fin_ok), .fin_fail(fin_fail), .last_sector(last_sector),
    .count_q(sec_count)
  );

  mst_status_flags #(.CODE_W(CODE_W)) u_flags (
    .clk(clk), .rst(rst), .clear(accept), .active(phase != PH_IDLE),
    .corr_in(corr_err), .fail(fin_fail), .cause(fatal_cause),
    .corr_q(st_corr), .err_q(st_err), .code_q(err_code)
  );
endmodule

// File: rtl/mst_xfer_tracker_checker.sv
module mst_xfer_tracker_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic [CNT_W-1:0] cmd_count,
  input logic             st_bsy,
  input logic             st_drq,
  input logic             st_corr,
  input logic             st_err,
  input logic             done,
  input logic [CNT_W-1:0] sec_count
);
  logic idle;
  assign idle = !st_bsy && !st_drq;

  a_r6_bsy_drq_excl: assert property (@(posedge clk) disable iff (rst)
    !(st_bsy && st_drq));

  a_r5_drq_from_bsy: assert property (@(posedge clk) disable iff (rst)
    $rose(st_drq) |-> $past(st_bsy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_in_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> idle);

  a_r2_ok_zero_count: assert property (@(posedge clk) disable iff (rst)
    (done && !st_err) |-> (sec_count == '0));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_start) |=> (st_bsy && !st_corr && !st_err));

  a_r10_start_loads: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_start) |=> (sec_count == $past(cmd_count)));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (idle && !cmd_start) |=> (idle && $stable(sec_count)));
endmodule

bind mst_xfer_tracker mst_xfer_tracker_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_count(cmd_count),
  .st_bsy(st_bsy), .st_drq(st_drq), .st_corr(st_corr), .st_err(st_err),
  .done(done), .sec_count(sec_count)
);

// File: tb/mst_xfer_tracker_bench.sv
`timescale 1ns/1ps
module mst_xfer_tracker_bench;
  localparam int CNT_W = 8, CODE_W = 8, SETTLE = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_start = 0, sec_done = 0, corr_err = 0, fatal_err = 0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [CODE_W-1:0] fatal_cause = '0;
  logic st_bsy, st_drq, st_corr, st_err, done;
  logic [CODE_W-1:0] err_code;
  logic [CNT_W-1:0]  sec_count;

  int vectors = 0, miscompares = 0;
  bit finished = 0, model_live = 0;

  always #4 clk = ~clk;

  mst_xfer_tracker #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SETTLE_CYC(SETTLE)) u_mst_xfer_tracker (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .sec_done(sec_done), .corr_err(corr_err), .fatal_err(fatal_err),
    .fatal_cause(fatal_cause), .st_bsy(st_bsy), .st_drq(st_drq),
    .st_corr(st_corr), .st_err(st_err), .err_code(err_code), .done(done),
    .sec_count(sec_count)
  );

  // Behavioural reference: mode 0 idle, 1 busy window, 2 data request
  int m_mode, m_left, m_wait, m_cnt, m_code;
  bit m_corr, m_err, m_done;

  always @(posedge clk) begin
    model_live <= 1'b1;
    m_done = 0;
    if (rst) begin
      m_mode = 0; m_left = 0; m_wait = 0; m_cnt = 0; m_code = 0;
      m_corr = 0; m_err = 0;
    end else if (m_mode == 0) begin
      if (cmd_start) begin
        m_mode = 1; m_wait = SETTLE; m_cnt = cmd_count;
        m_left = (cmd_count == 0) ? 256 : cmd_count;
        m_corr = 0; m_err = 0; m_code = 0;
      end
    end else begin
      if (corr_err) m_corr = 1;
      if (fatal_err) begin
        m_mode = 0; m_err = 1; m_code = fatal_cause;
        m_cnt = m_left % 256; m_done = 1;
      end else if (m_mode == 1) begin
        if (m_wait == 1) m_mode = 2; else m_wait = m_wait - 1;
      end else if (sec_done) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_mode = 0; m_cnt = 0; m_done = 1;
        end else begin
          m_mode = 1; m_wait = SETTLE;
        end
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_live && !finished) begin
      cmp(st_bsy, m_mode == 1, "R5 R6 busy");
      cmp(st_drq, m_mode == 2, "R5 R6 data-request");
      cmp(st_corr, m_corr, "R4 corrected flag");
      cmp(st_err, m_err, "R7 error flag");
      cmp(err_code, m_code, "R7 error code");
      cmp(done, m_done, "R8 completion pulse");
      cmp(sec_count, m_cnt, "R1 R2 R3 R10 sector count");
    end
  end

  task automatic start_cmd(input int c);
    @(negedge clk); cmd_start = 1; cmd_count = CNT_W'(c);
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic one_sector(input bit with_corr);
    @(negedge clk);
    while (!st_drq) @(negedge clk);
    sec_done = 1; corr_err = with_corr;
    @(negedge clk); sec_done = 0; corr_err = 0;
  endtask

  task automatic fail_now(input int cause, input bit with_sec);
    @(negedge clk);
    while (!st_drq) @(negedge clk);
    fatal_err = 1; sec_done = with_sec; fatal_cause = CODE_W'(cause);
    @(negedge clk); fatal_err = 0; sec_done = 0;
  endtask

  task automatic to_idle();
    while (st_bsy || st_drq) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_eq(input int act, input int exp, input string what);
    cmp(act, exp, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    expect_eq(st_bsy | st_drq | done, 0, "R6 reset idle");

    // R2: three-sector transfer ends with zero count
    start_cmd(3);
    repeat (3) one_sector(0);
    to_idle();
    expect_eq(sec_count, 0, "R2 residual after success");

    // R4: correctable error on second sector, transfer continues
    start_cmd(4);
    one_sector(0); one_sector(1); one_sector(0); one_sector(0);
    to_idle();
    expect_eq(st_corr, 1, "R4 corrected flag after completion");
    expect_eq(st_err, 0, "R4 no error from correctable");

    // R3 R7: fatal on third sector of five -> three owed
    start_cmd(5);
    one_sector(0); one_sector(0);
    fail_now(8'h40, 0);
    to_idle();
    expect_eq(sec_count, 3, "R3 residual after failure");
    expect_eq(err_code, 8'h40, "R7 latched cause");

    // R3: fatal in same cycle as a sector strobe, sector not counted
    start_cmd(2);
    one_sector(0);
    fail_now(8'h10, 1);
    to_idle();
    expect_eq(sec_count, 1, "R3 fatal beats same-cycle sector");

    // R7: fatal during the busy window
    start_cmd(6);
    @(negedge clk); fatal_err = 1; fatal_cause = 8'h04;
    @(negedge clk); fatal_err = 0;
    to_idle();
    expect_eq(sec_count, 6, "R7 fail while busy");

    // R9: ignored stimulus
    @(negedge clk); fatal_err = 1; corr_err = 1; sec_done = 1;
    @(negedge clk); fatal_err = 0; corr_err = 0; sec_done = 0;
    expect_eq(st_bsy | st_drq | done, 0, "R9 idle strobes ignored");
    start_cmd(2);
    sec_done = 1; cmd_start = 1; cmd_count = 8'd9;
    @(negedge clk); sec_done = 0; cmd_start = 0;
    expect_eq(sec_count, 2, "R9 restart while busy ignored");
    one_sector(0); one_sector(0);
    to_idle();
    expect_eq(sec_count, 0, "R9 count unaffected by ignored strobes");

    // R1: zero count means 256 sectors
    start_cmd(0);
    for (int i = 0; i < 255; i++) one_sector(0);
    expect_eq(st_bsy | st_drq, 1, "R1 still active after 255 sectors");
    one_sector(0);
    to_idle();
    expect_eq(sec_count, 0, "R1 completes after 256 sectors");

    // R3: zero count failing before any sector leaves low bits of 256
    start_cmd(0);
    fail_now(8'h01, 0);
    to_idle();
    expect_eq(sec_count, 0, "R3 residual of 256 truncated");
    expect_eq(st_err, 1, "R7 error flag set");

    // R7 R4: new start clears flags
    start_cmd(1);
    expect_eq(st_err | st_corr, 0, "R7 flags cleared by start");
    one_sector(0);
    to_idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule